// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a supervisory counter that restarts the system when software stops servicing it in time. A 16-bit up-counter advances on each cycle in which the `tick_i` input is high. Software cannot read or load the counter. It can only zero it, freeze it or retune it, through a single 16-bit control write.

A control write takes effect only when its upper byte carries the unlock key 0x5A. A write with any other upper byte is treated as evidence of runaway code, and a reset request is issued at once. Reads return the stored control byte in the lower half and a distinct fixed tag, 0x69, in the upper half. Because of this, reading the register and writing the value back can never unlock it.

The block has two modes. In supervisory mode, expiry of the chosen span raises a one-cycle reset request. In interval mode, expiry sets a sticky interrupt flag, and software clears that flag with `irq_ack_i`. Two control bits are reserved for configuring an external non-maskable interrupt pin. The block stores them but does not act on them.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset, `rd_data_o` reads 0x6900, `rst_req_o` is 0 and `irq_flag_o` is 0. This state selects supervisory mode, the longest span and a running counter.
- R2: `rd_data_o[15:8]` always reads 0x69. `rd_data_o[7:0]` returns the stored control byte, except that bit 3 (counter zero) always reads 0.
- R3: A write (`wr_en_i` high) whose bits [15:8] equal 0x5A stores bits [7:0] as the control byte, and it is visible on `rd_data_o` in the next cycle. The control byte is laid out as follows: bit 7 = freeze, bit 6 = external-interrupt edge, bit 5 = external-interrupt enable, bit 4 = mode (1 = interval), bit 3 = zero counter, bit 2 = spare, bits [1:0] = span select.
- R4: A write whose bits [15:8] differ from 0x5A leaves the control byte unchanged and drives `rst_req_o` high in the next cycle.
- R5: The span select values 0, 1, 2 and 3 make expiry happen on the 2^15th, 2^13th, 2^9th and 2^6th tick after the counter was last zeroed. On expiry the counter returns to zero.
- R6: In supervisory mode (bit 4 = 0), expiry drives `rst_req_o` high for the one cycle after the expiring tick, and `irq_flag_o` is left unchanged.
- R7: In interval mode (bit 4 = 1), expiry sets `irq_flag_o` in the next cycle and does not raise `rst_req_o`. The flag stays set until a cycle with `irq_ack_i` high. If an expiry and an acknowledge fall in the same cycle, the flag stays set.
- R8: While the freeze bit is 1, ticks do not advance the counter, and no expiry occurs.
- R9: An accepted write with bit 3 set zeroes the counter. If a tick would expire the counter in that same cycle, the zeroing wins and no expiry event is produced.
- R10: Bits 6 and 5 are stored and read back but have no effect on `rst_req_o` or `irq_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 16 | Write data: key in [15:8], control byte in [7:0] |
| irq_ack_i | input | 1 | Clears the interval interrupt flag |
| rd_data_o | output | 16 | Read tag 0x69 in [15:8], control byte in [7:0] |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_flag_o | output | 1 | Sticky interval-expiry flag |

## Verification
Three kinds of event can land in the same cycle as the counter's final tick: a zeroing write, a wrong-key write, and an interrupt acknowledge. The bench runs the counter to one tick short of the 64-tick span. It then presents the expiring tick together with each of these in turn. It judges the outcome at the ports. A zeroing write must suppress the reset, and a fresh full span must follow. A bad key during an interval expiry must yield both a reset request and the flag. An acknowledge that coincides with an expiry must leave the flag set.

// File: rtl/kw_pkg.sv
package kw_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] WR_KEY = 8'h5A;
    localparam logic [BYTE_W-1:0] RD_TAG = 8'h69;

    // span exponents selected by the 2-bit span field
    localparam int SPAN_E0 = 15;
    localparam int SPAN_E1 = 13;
    localparam int SPAN_E2 = 9;
    localparam int SPAN_E3 = 6;

    typedef struct packed {
        logic       freeze;    // bit 7
        logic       ext_fall;  // bit 6
        logic       ext_en;    // bit 5
        logic       itv_mode;  // bit 4
        logic       zero;      // bit 3
        logic       spare;     // bit 2
        logic [1:0] span;      // bits 1:0
    } kw_ctrl_t;

    function automatic logic [CNT_W-1:0] span_mask(input logic [1:0] s);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        case (s)
            2'd0:    span_mask = (one << SPAN_E0) - one;
            2'd1:    span_mask = (one << SPAN_E1) - one;
            2'd2:    span_mask = (one << SPAN_E2) - one;
            default: span_mask = (one << SPAN_E3) - one;
        endcase
    endfunction
endpackage

// File: rtl/kw_ctrl_reg.sv
module kw_ctrl_reg
    import kw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2*BYTE_W-1:0] wr_data,
    output kw_ctrl_t            ctrl,
    output logic                zero_pulse,
    output logic                key_fault
);
    logic     key_ok;
    kw_ctrl_t ctrl_q;
    kw_ctrl_t wr_ctrl;

    assign key_ok     = (wr_data[2*BYTE_W-1:BYTE_W] == WR_KEY);
    assign wr_ctrl    = kw_ctrl_t'(wr_data[BYTE_W-1:0]);
    assign zero_pulse = wr_en && key_ok && wr_ctrl.zero;
    assign key_fault  = wr_en && !key_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && key_ok) begin
            ctrl_q      <= wr_ctrl;
            ctrl_q.zero <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/kw_counter.sv
module kw_counter
    import kw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             freeze,
    input  logic [1:0]       span,
    input  logic             zero_pulse,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             step;

    assign mask   = span_mask(span);
    assign step   = tick && !freeze;
    assign expire = step && !zero_pulse && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || zero_pulse || expire) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/kw_event.sv
module kw_event (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic itv_mode,
    input  logic key_fault,
    input  logic irq_ack,
    output logic rst_req,
    output logic irq_flag
);
    logic rst_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            rst_q <= key_fault || (expire && !itv_mode);
            if (expire && itv_mode) begin
                irq_q <= 1'b1;
            end else if (irq_ack) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign rst_req  = rst_q;
    assign irq_flag = irq_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                wr_en_i,
    input  logic [2*BYTE_W-1:0] wr_data_i,
    input  logic                irq_ack_i,
    output logic [2*BYTE_W-1:0] rd_data_o,
    output logic                rst_req_o,
    output logic                irq_flag_o
);
    kw_ctrl_t         ctrl;
    logic             zero_pulse;
    logic             key_fault;
    logic [CNT_W-1:0] cnt_w;
    logic             expire;

    kw_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .wr_data    (wr_data_i),
        .ctrl       (ctrl),
        .zero_pulse (zero_pulse),
        .key_fault  (key_fault)
    );

    kw_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_i),
        .freeze     (ctrl.freeze),
        .span       (ctrl.span),
        .zero_pulse (zero_pulse),
        .cnt        (cnt_w),
        .expire     (expire)
    );

    kw_event u_evt (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .itv_mode  (ctrl.itv_mode),
        .key_fault (key_fault),
        .irq_ack   (irq_ack_i),
        .rst_req   (rst_req_o),
        .irq_flag  (irq_flag_o)
    );

    assign rd_data_o = {RD_TAG, ctrl};
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import kw_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en_i,
    input logic [2*BYTE_W-1:0] wr_data_i,
    input logic                tick_i,
    input logic [2*BYTE_W-1:0] rd_data_o,
    input logic                rst_req_o,
    input logic                irq_flag_o,
    input logic [CNT_W-1:0]    cnt_w
);
    // R4: a wrong key is followed by a reset request
    p_bad_key_reset_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[15:8] != WR_KEY) |=> rst_req_o);

    // R3: an accepted write is visible, with the zero bit reading 0 (R2)
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[15:8] == WR_KEY) |=>
        (rd_data_o[7:0] == ($past(wr_data_i[7:0]) & 8'hF7)));

    // R2: readback holds without a write
    p_read_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(rd_data_o));

    // R8: the counter stays still while frozen
    p_freeze_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[7] && !wr_en_i) |=> $stable(cnt_w));

    // R7: the flag rises only for interval mode
    p_irq_mode_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag_o) |-> $past(rd_data_o[4]));

    // R6: in interval mode only a bad key requests reset
    p_no_rst_itv_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(wr_en_i && wr_data_i[15:8] != WR_KEY) || !$past(rd_data_o[4])));
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .tick_i     (tick_i),
    .rd_data_o  (rd_data_o),
    .rst_req_o  (rst_req_o),
    .irq_flag_o (irq_flag_o),
    .cnt_w      (cnt_w)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        irq_ack_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        rst_req_o;
    logic        irq_flag_o;

    int checks = 0;
    int failures = 0;
    int rst_seen = 0;
    int base;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o),
        .rst_req_o(rst_req_o), .irq_flag_o(irq_flag_o)
    );

    always @(negedge clk) if (rst_req_o) rst_seen++;

    // {write data, expected readback, expected reset request}
    localparam logic [32:0] VECS [0:7] = '{
        {16'h5A97, 16'h6997, 1'b0},
        {16'h5AFF, 16'h69F7, 1'b0},
        {16'h1200, 16'h69F7, 1'b1},
        {16'h5A08, 16'h6900, 1'b0},
        {16'hA55A, 16'h6900, 1'b1},
        {16'h5A34, 16'h6934, 1'b0},
        {16'h6900, 16'h6934, 1'b1},
        {16'h5A00, 16'h6900, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack_i = 1'b1;
        @(negedge clk); irq_ack_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 readback", rd_data_o, 16'h6900);
        chk("R1 rst_req", {15'b0, rst_req_o}, 16'h0);
        chk("R1 irq", {15'b0, irq_flag_o}, 16'h0);

        for (int i = 0; i < 8; i++) begin
            wr(VECS[i][32:17]);
            chk("R2 R3 table readback", rd_data_o, VECS[i][16:1]);
            chk("R4 table rst_req", {15'b0, rst_req_o}, {15'b0, VECS[i][0]});
        end

        // R5 R6: span 0 in supervisory mode
        wr(16'h5A08); base = rst_seen;
        ticks(32767);
        chk("R5 span0 early", 16'(rst_seen - base), 16'd0);
        ticks(1);
        chk("R6 span0 expiry", {15'b0, rst_req_o}, 16'h1);
        chk("R6 irq untouched", {15'b0, irq_flag_o}, 16'h0);
        @(negedge clk);
        chk("R6 one-cycle pulse", {15'b0, rst_req_o}, 16'h0);

        // R5 R7: span 1 interval
        wr(16'h5A19);
        chk("R2 zero bit reads 0", rd_data_o, 16'h6911);
        base = rst_seen;
        ticks(8191);
        chk("R5 span1 early", {15'b0, irq_flag_o}, 16'h0);
        ticks(1);
        chk("R7 span1 flag", {15'b0, irq_flag_o}, 16'h1);
        repeat (3) @(negedge clk);
        chk("R7 flag sticky", {15'b0, irq_flag_o}, 16'h1);
        chk("R7 no reset", 16'(rst_seen - base), 16'd0);
        ack();
        chk("R7 ack clears", {15'b0, irq_flag_o}, 16'h0);

        // R5: span 2 interval
        wr(16'h5A1A);
        ticks(511);
        chk("R5 span2 early", {15'b0, irq_flag_o}, 16'h0);
        ticks(1);
        chk("R5 span2 flag", {15'b0, irq_flag_o}, 16'h1);
        ack();

        // R8: freeze
        wr(16'h5A8B); base = rst_seen;
        ticks(200);
        chk("R8 frozen no expiry", 16'(rst_seen - base), 16'd0);
        wr(16'h5A03);
        ticks(63);
        chk("R8 resumed from zero", 16'(rst_seen - base), 16'd0);
        ticks(1);
        chk("R5 span3 expiry", {15'b0, rst_req_o}, 16'h1);

        // R9: zeroing write on the expiring tick
        wr(16'h5A0B); base = rst_seen;
        ticks(63);
        @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'h5A0B;
        @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R9 zero beats expiry", {15'b0, rst_req_o}, 16'h0);
        ticks(63);
        chk("R9 fresh span", 16'(rst_seen - base), 16'd0);
        ticks(1);
        chk("R9 expiry after fresh span", {15'b0, rst_req_o}, 16'h1);

        // R4 with interval expiry in the same cycle
        wr(16'h5A1B);
        ticks(63);
        @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'h0000;
        @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R4 bad key reset", {15'b0, rst_req_o}, 16'h1);
        chk("R7 flag with bad key", {15'b0, irq_flag_o}, 16'h1);
        chk("R4 control kept", rd_data_o, 16'h6913);
        ack();

        // R7: acknowledge and expiry together
        wr(16'h5A1B);
        ticks(63);
        @(negedge clk); tick_i = 1'b1; irq_ack_i = 1'b1;
        @(negedge clk); tick_i = 1'b0; irq_ack_i = 1'b0;
        chk("R7 set beats ack", {15'b0, irq_flag_o}, 16'h1);
        ack();
        chk("R7 later ack", {15'b0, irq_flag_o}, 16'h0);

        // R10: external interrupt bits have no effect
        wr(16'h5A6B);
        chk("R10 readback", rd_data_o, 16'h6963);
        base = rst_seen;
        ticks(63);
        chk("R10 no early event", 16'(rst_seen - base), 16'd0);
        ticks(1);
        chk("R10 normal expiry", {15'b0, rst_req_o}, 16'h1);
        chk("R10 no irq", {15'b0, irq_flag_o}, 16'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule